// File: doc/BRIEF.md
# Dual-Buffer Flash Operation Sequencer

This block sequences the work behind a page-organized serial flash that has two SRAM staging buffers. A front end that has already shifted in and decoded a command hands it over as one cycle of `cmd_valid` with an operation code, a buffer select, a page number, a byte index and write data. Host buffer accesses finish in one cycle. The three array operations are program (buffer into page), load (page into buffer) and compare (buffer against page). Each one is self-timed by an internal step counter and holds `busy_n` low for its whole run. The flash array is a small behavioural memory inside the block.

An array operation claims only the array and the buffer it names. The other buffer stays open to host reads and writes. A command that needs a claimed resource is dropped and flagged. When the write-protect input is low, the lowest `PROT_PAGES` pages cannot be programmed. The active-low `abort_n` input cancels any running operation and keeps the sequencer idle for as long as it stays low.

Top module: `dfb_seq`

## Requirements
- R1: After `rst`, `busy_n`=1 and `rd_valid`, `prot_err`, `cmd_rej` and `cmp_diff` are all 0.
- R2: Operation code 1 writes `cmd_wdata` into byte `cmd_byte` of buffer `cmd_buf` (0 or 1). Operation code 2 reads that byte: `rd_valid`=1 and `rd_data` appear in the cycle after the read command.
- R3: An accepted array operation drives `busy_n` low from the cycle after acceptance for exactly `OP_CYCLES` cycles.
- R4: Operation code 4 copies every byte of page `cmd_page` into buffer `cmd_buf`.
- R5: Operation code 5 compares buffer `cmd_buf` with page `cmd_page`. When busy is released, `cmp_diff` becomes 1 on any mismatch and 0 on a full match. `cmp_diff` does not change at any other time.
- R6: Operation code 3 aimed at a page below `PROT_PAGES` while `wp_n`=0 is refused. `prot_err` pulses for one cycle in the cycle after the command, `busy_n` stays 1 and the page is unchanged.
- R7: With `wp_n`=1, operation code 3 writes buffer `cmd_buf` into a page below `PROT_PAGES`.
- R8: While busy, reads and writes to the buffer not used by the running operation are served as in R2.
- R9: While busy, a host access to the busy buffer, or any array operation (codes 3 to 5), has no effect, and `cmd_rej` pulses in the cycle after the command.
- R10: `abort_n`=0 releases `busy_n` in the next cycle. Commands issued while it is low have no effect and raise no flag. Once `abort_n` returns to 1, operations run normally.
- R11: Operation code 3 aimed at a page at or above `PROT_PAGES` is accepted while `wp_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_n | input | 1 | Active-low operation abort, held idle while low |
| wp_n | input | 1 | Active-low write protect for the low page range |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 3 | Operation code: 1 write, 2 read, 3 program, 4 load, 5 compare |
| cmd_buf | input | 1 | Buffer select |
| cmd_page | input | PAGE_W | Target page |
| cmd_byte | input | BYTE_W | Byte index within the buffer |
| cmd_wdata | input | DATA_W | Write data for buffer writes |
| rd_valid | output | 1 | Buffer read data valid |
| rd_data | output | DATA_W | Buffer read data |
| busy_n | output | 1 | Low while a self-timed operation runs |
| cmp_diff | output | 1 | Result of the last completed compare: 1 means mismatch |
| prot_err | output | 1 | One-cycle pulse for a refused protected program |
| cmd_rej | output | 1 | One-cycle pulse for a command dropped due to busy |

## Verification
The buffers are filled with patterns that differ per buffer and per byte, so a load or program that swaps buffers, bytes or pages gives a visible mismatch on read-back. Compare is run three times: on a matching buffer, on a buffer with one corrupted byte, and then on a match again. This shows that the result both sets and clears, and that it holds steady while the operation runs. Protection is probed at pages 5, 255 and 256 with `wp_n` low, and at page 5 with `wp_n` high, which locates the boundary exactly. During a program, accesses to the free buffer are mixed with accesses to the busy buffer and with array commands, to show that only the claimed resources are locked out.

// File: rtl/dfb_pkg.sv
package dfb_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_BWR  = 3'd1,
    OP_BRD  = 3'd2,
    OP_PROG = 3'd3,
    OP_LOAD = 3'd4,
    OP_CMP  = 3'd5
  } dfb_op_e;
endpackage

// File: rtl/dfb_ram.sv
// Simple dual-port memory: one synchronous write port, one registered read port.
module dfb_ram #(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dfb_ctrl.sv
// Command arbitration, write-protect screening and self-timed step counter.
module dfb_ctrl
  import dfb_pkg::*;
#(
  parameter int PAGE_W     = 9,
  parameter int PROT_PAGES = 256,
  parameter int OP_CYCLES  = 16,
  parameter int STEP_W     = $clog2(OP_CYCLES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_buf,
  input  logic [PAGE_W-1:0] cmd_page,
  output logic              busy,
  output dfb_op_e           act_op,
  output logic              act_buf,
  output logic [PAGE_W-1:0] act_page,
  output logic [STEP_W-1:0] step,
  output logic              done,
  output logic              host_go,
  output logic              prot_err,
  output logic              cmd_rej
);
  localparam logic [STEP_W-1:0] LAST     = STEP_W'(OP_CYCLES - 1);
  localparam logic [PAGE_W:0]   PROT_LIM = (PAGE_W + 1)'(PROT_PAGES);

  dfb_op_e op;
  logic is_host, is_arr, live, prot_hit, buf_clash;
  logic start, rej_now, prot_now;

  assign op        = dfb_op_e'(cmd_op);
  assign is_host   = (op == OP_BWR) || (op == OP_BRD);
  assign is_arr    = (op == OP_PROG) || (op == OP_LOAD) || (op == OP_CMP);
  assign live      = cmd_valid && abort_n;
  assign prot_hit  = (op == OP_PROG) && ({1'b0, cmd_page} < PROT_LIM) && !wp_n;
  assign buf_clash = busy && (cmd_buf == act_buf);

  assign host_go  = live && is_host && !buf_clash;
  assign rej_now  = live && ((is_host && buf_clash) || (is_arr && busy));
  assign start    = live && is_arr && !busy && !prot_hit;
  assign prot_now = live && is_arr && !busy && prot_hit;
  assign done     = busy && abort_n && (step == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      step     <= '0;
      act_op   <= OP_NONE;
      act_buf  <= 1'b0;
      act_page <= '0;
      prot_err <= 1'b0;
      cmd_rej  <= 1'b0;
    end else begin
      prot_err <= prot_now;
      cmd_rej  <= rej_now;
      if (!abort_n) begin
        busy <= 1'b0;
        step <= '0;
      end else if (start) begin
        busy     <= 1'b1;
        step     <= '0;
        act_op   <= op;
        act_buf  <= cmd_buf;
        act_page <= cmd_page;
      end else if (busy) begin
        if (done) begin
          busy <= 1'b0;
          step <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dfb_seq.sv
// Dual-buffer flash operation sequencer (top).
module dfb_seq
  import dfb_pkg::*;
#(
  parameter int PAGES      = 512,
  parameter int PAGE_BYTES = 4,
  parameter int DATA_W     = 8,
  parameter int PROT_PAGES = 256,
  parameter int OP_CYCLES  = 16,
  parameter int PAGE_W     = $clog2(PAGES),
  parameter int BYTE_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_buf,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy_n,
  output logic              cmp_diff,
  output logic              prot_err,
  output logic              cmd_rej
);
  localparam int STEP_W = $clog2(OP_CYCLES);
  localparam int ARR_W  = PAGE_W + BYTE_W;
  localparam logic [STEP_W-1:0] XFER_END = STEP_W'(PAGE_BYTES);

  logic              busy, done, host_go, act_buf;
  dfb_op_e           act_op;
  logic [PAGE_W-1:0] act_page;
  logic [STEP_W-1:0] step, step_m1;
  logic              in_xfer;
  logic [1:0][DATA_W-1:0] bq;
  logic [DATA_W-1:0] arr_q;
  logic              cmp_acc, rd_buf_q;

  dfb_ctrl #(
    .PAGE_W(PAGE_W), .PROT_PAGES(PROT_PAGES),
    .OP_CYCLES(OP_CYCLES), .STEP_W(STEP_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .abort_n(abort_n), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_buf(cmd_buf),
    .cmd_page(cmd_page), .busy(busy), .act_op(act_op),
    .act_buf(act_buf), .act_page(act_page), .step(step),
    .done(done), .host_go(host_go), .prot_err(prot_err),
    .cmd_rej(cmd_rej)
  );

  assign step_m1 = step - 1'b1;
  assign in_xfer = busy && (step != '0) && (step <= XFER_END);

  // Two staging buffers; port ownership goes to the operation when it claims the buffer.
  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic              own, we;
    logic [BYTE_W-1:0] waddr, raddr;
    logic [DATA_W-1:0] wdata;

    assign own   = busy && (act_buf == 1'(b));
    assign we    = own ? (in_xfer && act_op == OP_LOAD)
                       : (host_go && cmd_op == OP_BWR && cmd_buf == 1'(b));
    assign waddr = own ? step_m1[BYTE_W-1:0] : cmd_byte;
    assign wdata = own ? arr_q : cmd_wdata;
    assign raddr = own ? step[BYTE_W-1:0] : cmd_byte;

    dfb_ram #(.AW(BYTE_W), .DW(DATA_W)) u_buf (
      .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(bq[b])
    );
  end

  // Behavioural flash array, page-major addressing.
  logic             arr_we;
  logic [ARR_W-1:0] arr_waddr, arr_raddr;

  assign arr_we    = in_xfer && (act_op == OP_PROG);
  assign arr_waddr = {act_page, step_m1[BYTE_W-1:0]};
  assign arr_raddr = {act_page, step[BYTE_W-1:0]};

  dfb_ram #(.AW(ARR_W), .DW(DATA_W)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(bq[act_buf]),
    .raddr(arr_raddr), .rdata(arr_q)
  );

  // Compare accumulation and result latch; host read return path.
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_acc  <= 1'b0;
      cmp_diff <= 1'b0;
      rd_valid <= 1'b0;
      rd_buf_q <= 1'b0;
    end else begin
      rd_valid <= host_go && (cmd_op == OP_BRD);
      rd_buf_q <= cmd_buf;
      if (!busy) begin
        cmp_acc <= 1'b0;
      end else if (act_op == OP_CMP && in_xfer && arr_q != bq[act_buf]) begin
        cmp_acc <= 1'b1;
      end
      if (done && act_op == OP_CMP) cmp_diff <= cmp_acc;
    end
  end

  assign rd_data = bq[rd_buf_q];
  assign busy_n  = ~busy;
endmodule

// File: rtl/dfb_seq_chk.sv
module dfb_seq_chk #(
  parameter int OP_CYCLES = 16
) (
  input logic clk,
  input logic rst,
  input logic abort_n,
  input logic cmd_valid,
  input logic rd_valid,
  input logic busy_n,
  input logic cmp_diff,
  input logic prot_err,
  input logic cmd_rej
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (rst || busy_n) busy_run <= 0;
    else               busy_run <= busy_run + 1;
  end

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst) !busy_n |-> busy_run < OP_CYCLES); // R3
  AST_READ_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst) rd_valid |-> $past(cmd_valid && abort_n)); // R2
  AST_CMP_HELD: assert property (@(posedge clk) disable iff (rst) (busy_n && $past(busy_n)) |-> $stable(cmp_diff)); // R5
  AST_PROT_NO_BUSY: assert property (@(posedge clk) disable iff (rst) prot_err |-> busy_n); // R6
  AST_REJ_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst) cmd_rej |-> $past(!busy_n)); // R9
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst) !abort_n |=> busy_n); // R10
endmodule

bind dfb_seq dfb_seq_chk #(.OP_CYCLES(OP_CYCLES)) u_dfb_chk (
  .clk(clk), .rst(rst), .abort_n(abort_n), .cmd_valid(cmd_valid),
  .rd_valid(rd_valid), .busy_n(busy_n), .cmp_diff(cmp_diff),
  .prot_err(prot_err), .cmd_rej(cmd_rej)
);

// File: tb/test_dfb_seq.sv
`timescale 1ns/1ps
module test_dfb_seq;
  localparam int OPC = 16;
  localparam int PB  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       abort_n = 1'b1;
  logic       wp_n = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic       cmd_buf = 1'b0;
  logic [8:0] cmd_page = '0;
  logic [1:0] cmd_byte = '0;
  logic [7:0] cmd_wdata = '0;
  logic       rd_valid, busy_n, cmp_diff, prot_err, cmd_rej;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mdl [2][PB];

  always #2.5 clk = ~clk;

  dfb_seq i_dfb_seq (
    .clk(clk), .rst(rst), .abort_n(abort_n), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_buf(cmd_buf),
    .cmd_page(cmd_page), .cmd_byte(cmd_byte), .cmd_wdata(cmd_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy_n(busy_n),
    .cmp_diff(cmp_diff), .prot_err(prot_err), .cmd_rej(cmd_rej)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives one command at a negedge; returns at the negedge after the accepting edge.
  task automatic issue(input logic [2:0] op, input logic b, input logic [8:0] pg,
                       input logic [1:0] by, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_buf = b; cmd_page = pg; cmd_byte = by; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_n === 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic fill(input logic b, input logic [7:0] base);
    for (int i = 0; i < PB; i++) begin
      issue(3'd1, b, 9'd0, 2'(i), base + 8'(i));
      mdl[b][i] = base + 8'(i);
    end
  endtask

  task automatic read_chk(input string req, input logic b, input int i, input logic [7:0] exp);
    issue(3'd2, b, 9'd0, 2'(i), 8'h00);
    check({req, " rd_valid"}, 32'(rd_valid), 32'd1);
    check({req, " rd_data"}, 32'(rd_data), 32'(exp));
  endtask

  task automatic t_reset;
    check("R1 busy_n", 32'(busy_n), 32'd1);
    check("R1 rd_valid", 32'(rd_valid), 32'd0);
    check("R1 prot_err", 32'(prot_err), 32'd0);
    check("R1 cmd_rej", 32'(cmd_rej), 32'd0);
    check("R1 cmp_diff", 32'(cmp_diff), 32'd0);
  endtask

  task automatic t_bufrw;
    fill(1'b0, 8'h10);
    fill(1'b1, 8'h20);
    for (int i = 0; i < PB; i++) read_chk("R2 buf0", 1'b0, i, mdl[0][i]);
    for (int i = 0; i < PB; i++) read_chk("R2 buf1", 1'b1, i, mdl[1][i]);
  endtask

  task automatic t_program;
    int n;
    wp_n = 1'b0;
    issue(3'd3, 1'b0, 9'd300, 2'd0, 8'h00);
    wait_idle(n);
    check("R3 busy length", 32'(n), 32'(OPC));
    issue(3'd4, 1'b1, 9'd300, 2'd0, 8'h00);
    wait_idle(n);
    check("R3 load busy length", 32'(n), 32'(OPC));
    for (int i = 0; i < PB; i++) mdl[1][i] = mdl[0][i];
    for (int i = 0; i < PB; i++) read_chk("R4 R11 loaded page", 1'b1, i, mdl[1][i]);
  endtask

  task automatic t_compare;
    int n;
    issue(3'd5, 1'b1, 9'd300, 2'd0, 8'h00);
    wait_idle(n);
    check("R5 match", 32'(cmp_diff), 32'd0);
    issue(3'd1, 1'b1, 9'd0, 2'd2, 8'h99);
    mdl[1][2] = 8'h99;
    issue(3'd5, 1'b1, 9'd300, 2'd0, 8'h00);
    repeat (3) @(negedge clk);
    check("R5 held while busy", 32'(cmp_diff), 32'd0);
    wait_idle(n);
    check("R5 mismatch", 32'(cmp_diff), 32'd1);
    issue(3'd5, 1'b0, 9'd300, 2'd0, 8'h00);
    wait_idle(n);
    check("R5 match again", 32'(cmp_diff), 32'd0);
  endtask

  task automatic t_protect;
    int n;
    wp_n = 1'b1;
    fill(1'b1, 8'h40);
    issue(3'd3, 1'b1, 9'd5, 2'd0, 8'h00);
    check("R7 program accepted", 32'(busy_n), 32'd0);
    wait_idle(n);
    wp_n = 1'b0;
    fill(1'b0, 8'h70);
    issue(3'd3, 1'b0, 9'd5, 2'd0, 8'h00);
    check("R6 prot_err pulse", 32'(prot_err), 32'd1);
    check("R6 no busy", 32'(busy_n), 32'd1);
    @(negedge clk);
    check("R6 pulse one cycle", 32'(prot_err), 32'd0);
    issue(3'd3, 1'b0, 9'd255, 2'd0, 8'h00);
    check("R6 page 255 refused", 32'(prot_err), 32'd1);
    issue(3'd4, 1'b0, 9'd5, 2'd0, 8'h00);
    wait_idle(n);
    for (int i = 0; i < PB; i++) mdl[0][i] = mdl[1][i];
    for (int i = 0; i < PB; i++) read_chk("R6 R7 page5 content", 1'b0, i, mdl[0][i]);
    issue(3'd3, 1'b0, 9'd256, 2'd0, 8'h00);
    check("R11 page 256 accepted", 32'(busy_n), 32'd0);
    check("R11 no prot_err", 32'(prot_err), 32'd0);
    wait_idle(n);
  endtask

  task automatic t_busy_other;
    int n;
    issue(3'd3, 1'b0, 9'd310, 2'd0, 8'h00);
    issue(3'd1, 1'b1, 9'd0, 2'd1, 8'hA5);
    mdl[1][1] = 8'hA5;
    check("R8 write no rej", 32'(cmd_rej), 32'd0);
    read_chk("R8 other buffer", 1'b1, 1, 8'hA5);
    issue(3'd1, 1'b0, 9'd0, 2'd1, 8'hFF);
    check("R9 busy buf write rej", 32'(cmd_rej), 32'd1);
    issue(3'd2, 1'b0, 9'd0, 2'd1, 8'h00);
    check("R9 busy buf read rej", 32'(cmd_rej), 32'd1);
    check("R9 busy buf no data", 32'(rd_valid), 32'd0);
    issue(3'd4, 1'b1, 9'd7, 2'd0, 8'h00);
    check("R9 array op rej", 32'(cmd_rej), 32'd1);
    check("R9 still busy", 32'(busy_n), 32'd0);
    wait_idle(n);
    read_chk("R9 busy buf unchanged", 1'b0, 1, mdl[0][1]);
    read_chk("R9 other buf kept", 1'b1, 1, 8'hA5);
  endtask

  task automatic t_abort;
    int n;
    issue(3'd3, 1'b0, 9'd320, 2'd0, 8'h00);
    repeat (2) @(negedge clk);
    abort_n = 1'b0;
    @(negedge clk);
    check("R10 busy released", 32'(busy_n), 32'd1);
    issue(3'd1, 1'b1, 9'd0, 2'd0, 8'hEE);
    check("R10 no rej", 32'(cmd_rej), 32'd0);
    issue(3'd2, 1'b1, 9'd0, 2'd0, 8'h00);
    check("R10 read ignored", 32'(rd_valid), 32'd0);
    issue(3'd5, 1'b1, 9'd300, 2'd0, 8'h00);
    check("R10 compare ignored", 32'(busy_n), 32'd1);
    abort_n = 1'b1;
    @(negedge clk);
    read_chk("R10 write ignored", 1'b1, 0, mdl[1][0]);
    issue(3'd3, 1'b1, 9'd321, 2'd0, 8'h00);
    wait_idle(n);
    check("R10 resumes", 32'(n), 32'(OPC));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_bufrw;
    t_program;
    t_compare;
    t_protect;
    t_busy_other;
    t_abort;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule